// File: doc/BRIEF.md
# Downlink Command Parser with Serial Password Check

This block sits behind the gap decoder of a contactless tag. It takes decoded downlink bits one at a time, together with a strobe that marks the end of a frame. When the frame ends, it turns the frame into one command. It identifies the two-bit opcode and judges legality by the exact total bit count, which depends on the opcode and on whether password mode is on. It compares the password against the stored word bit by bit as the bits arrive. It then extracts the page, the lock bit, the data word and the block address.

On the clock edge that samples the frame-end strobe, the block reports the result as a one-cycle command pulse. The pulse carries a command type, the extracted fields, and an error or locked flag. The block also keeps two pieces of state. One is the page chosen by the last accepted page opcode. The other is a wake flag that controls a modulation-enable output when answer-on-request mode is active. EEPROM programming is left to the consumer of the command.

Top module: `dl_cmd_parser`

## Requirements
- R1: The first two bits of a frame are the opcode. "1p" is a page command where p (the second bit) is the page. "00" is a reset and "01" is a test command. Command type codes are 0 none, 1 write, 2 direct access, 3 reset, 4 page read, 5 wake-up and 6 test.
- R2: With password mode off, a page opcode is legal only at 2 bits (page read), at 38 bits (write), or at 6 bits when the third bit is 0 (direct access). A "00" opcode is legal only at 2 bits.
- R3: With password mode on, a page opcode is legal only at 2 bits (page read), at 70 bits (write), at 38 bits when bit 35 (1-based) is 0 (direct access), or at 34 bits with opcode "10" (wake-up).
- R4: The bit after the opcode and any password is reported as cmd_lock. The next 32 bits form cmd_data, with the first-received bit in bit 31. The last 3 bits of the frame form cmd_addr, with the first-received bit as its MSB.
- R5: Password bits are compared serially, the first one with stored_pwd[31]. Any mismatch in a command that needs the password gives cmd_err=1 with type 0.
- R6: A test command gives type 6 unless master_key equals 6. In that case no cmd_vld pulse is produced and no state changes.
- R7: A legal write to a block whose lock_bits[cmd_addr] is 1, or any legal write while otp is 1, reports type 1 with cmd_locked=1 and cmd_err=0.
- R8: A wrong bit count, or a bit_err pulse during the frame, gives cmd_err=1 with type 0 and leaves cur_page unchanged.
- R9: Every accepted page command sets cur_page to its page bit. An accepted reset sets cur_page to 0. Both are visible with the cmd_vld pulse.
- R10: mod_en equals !aor_mode or the wake flag. A valid wake-up sets the flag. A reset command, a password mismatch on a page command of 34 bits or more in password mode, or rst_n clears it.
- R11: Results are registered on the edge that samples frame_end. cmd_vld lasts one cycle, and the next frame starts counting from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_vld | input | 1 | One decoded downlink bit is present |
| bit_val | input | 1 | Value of that bit |
| bit_err | input | 1 | Gap interval out of range during the current frame |
| frame_end | input | 1 | End-of-frame strobe |
| pwd_mode | input | 1 | Password mode enabled |
| aor_mode | input | 1 | Answer-on-request mode enabled |
| master_key | input | 4 | Configuration key that gates test commands |
| stored_pwd | input | 32 | Stored password word |
| lock_bits | input | 8 | Per-block write-lock flags |
| otp | input | 1 | Global write protection |
| cmd_vld | output | 1 | One-cycle result strobe |
| cmd_type | output | 3 | Command type code |
| cmd_page | output | 1 | Page bit of the opcode |
| cmd_lock | output | 1 | Lock bit carried by a write |
| cmd_data | output | 32 | Data word of a write |
| cmd_addr | output | 3 | Block address |
| cmd_err | output | 1 | Frame rejected |
| cmd_locked | output | 1 | Write refused because the target is protected |
| cur_page | output | 1 | Page of the last accepted page command |
| mod_en | output | 1 | Modulation enable |

## Verification
The assertions assume that bit_vld and frame_end are never high in the same cycle. They also assume that the configuration inputs stay steady for the duration of a frame. The bench respects both assumptions. It drives each bit and the strobe on separate falling edges, and it changes the mode, the key, the password and the protection inputs only between frames. Expected results come from the frame lengths and field values that the bench builds itself. Sweeps over every length up to beyond the longest frame, over every address, and over every password position cover the boundaries.

// File: rtl/dl_cmd_pkg.sv
package dl_cmd_pkg;
   localparam int OP_W = 2;
   typedef enum logic [2:0] {
      CMD_NONE  = 3'd0,
      CMD_WRITE = 3'd1,
      CMD_DIRECT = 3'd2,
      CMD_RESET = 3'd3,
      CMD_PAGE  = 3'd4,
      CMD_WAKE  = 3'd5,
      CMD_TEST  = 3'd6
   } cmd_e;
endpackage

// File: rtl/dl_bit_counter.sv
module dl_bit_counter #(
   parameter int SAT   = 71,
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_vld,
   input  logic             clr,
   output logic [CNT_W-1:0] idx
);
   localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT);

   if (SAT >= (1 << CNT_W)) begin : g_bad_w
      $error("counter too narrow for saturation value");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (clr) begin
         idx <= '0;
      end else if (bit_vld && idx != SAT_V) begin
         idx <= idx + 1'b1;
      end
   end

   // R11
   cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n) idx <= SAT_V);
   // R11
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) clr |=> idx == '0);
endmodule

// File: rtl/dl_pwd_cmp.sv
module dl_pwd_cmp #(
   parameter int PWD_W     = 32,
   parameter int OP_W      = 2,
   parameter int CNT_W     = 7,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_vld,
   input  logic             bit_val,
   input  logic             clr,
   input  logic [CNT_W-1:0] idx,
   input  logic [PWD_W-1:0] stored_pwd,
   output logic             ok
);
   localparam int POS_W = $clog2(PWD_W);
   localparam logic [CNT_W-1:0] LO = CNT_W'(OP_W);
   localparam logic [CNT_W-1:0] HI = CNT_W'(OP_W + PWD_W - 1);

   logic             in_win;
   logic [POS_W-1:0] pos;
   logic             ref_bit;

   assign in_win = bit_vld && (idx >= LO) && (idx <= HI);
   assign pos    = POS_W'(idx - LO);

   if (MSB_FIRST) begin : g_msb
      assign ref_bit = stored_pwd[POS_W'(PWD_W - 1) - pos];
   end else begin : g_lsb
      assign ref_bit = stored_pwd[pos];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ok <= 1'b1;
      end else if (clr) begin
         ok <= 1'b1;
      end else if (in_win && (bit_val != ref_bit)) begin
         ok <= 1'b0;
      end
   end

   // R5
   pwd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) (!ok && !clr) |=> !ok);
endmodule

// File: rtl/dl_field_cap.sv
module dl_field_cap #(
   parameter int OP_W      = 2,
   parameter int PWD_W     = 32,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 3,
   parameter int CNT_W     = 7,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_vld,
   input  logic              bit_val,
   input  logic              clr,
   input  logic              pwd_mode,
   input  logic [CNT_W-1:0]  idx,
   output logic [OP_W-1:0]   op,
   output logic              mark,
   output logic [DATA_W-1:0] data,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [CNT_W-1:0] BASE_P = CNT_W'(OP_W + PWD_W);
   localparam logic [CNT_W-1:0] BASE_N = CNT_W'(OP_W);
   localparam logic [CNT_W-1:0] DW     = CNT_W'(DATA_W);

   logic [CNT_W-1:0]  base;
   logic              in_data;
   logic [DATA_W-1:0] data_nxt;

   assign base    = pwd_mode ? BASE_P : BASE_N;
   assign in_data = (idx > base) && (idx <= base + DW);

   if (MSB_FIRST) begin : g_msb
      assign data_nxt = {data[DATA_W-2:0], bit_val};
   end else begin : g_lsb
      assign data_nxt = {bit_val, data[DATA_W-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op   <= '0;
         mark <= 1'b0;
         data <= '0;
         addr <= '0;
      end else if (clr) begin
         op   <= '0;
         mark <= 1'b0;
         data <= '0;
         addr <= '0;
      end else if (bit_vld) begin
         if (idx < CNT_W'(OP_W)) begin
            op <= {op[OP_W-2:0], bit_val};
         end
         if (idx == base) begin
            mark <= bit_val;
         end
         if (in_data) begin
            data <= data_nxt;
         end
         addr <= {addr[ADDR_W-2:0], bit_val};
      end
   end
endmodule

// File: rtl/dl_decode.sv
module dl_decode
   import dl_cmd_pkg::*;
#(
   parameter int PWD_W    = 32,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 3,
   parameter int NBLK     = 8,
   parameter int KEY_W    = 4,
   parameter int TEST_KEY = 6,
   parameter int CNT_W    = 7,
   parameter int SAT      = 71
) (
   input  logic [CNT_W-1:0]  cnt,
   input  logic [OP_W-1:0]   op,
   input  logic              mark,
   input  logic              pwd_ok,
   input  logic              pwd_mode,
   input  logic              int_err,
   input  logic [KEY_W-1:0]  master_key,
   input  logic [ADDR_W-1:0] addr,
   input  logic [NBLK-1:0]   lock_bits,
   input  logic              otp,
   output cmd_e              typ,
   output logic              err,
   output logic              locked,
   output logic              ignore,
   output logic              pwd_fail
);
   localparam logic [CNT_W-1:0] L_SHORT = CNT_W'(OP_W);
   localparam logic [CNT_W-1:0] L_WR    = CNT_W'(OP_W + 1 + DATA_W + ADDR_W);
   localparam logic [CNT_W-1:0] L_WRP   = CNT_W'(OP_W + PWD_W + 1 + DATA_W + ADDR_W);
   localparam logic [CNT_W-1:0] L_DA    = CNT_W'(OP_W + 1 + ADDR_W);
   localparam logic [CNT_W-1:0] L_DAP   = CNT_W'(OP_W + PWD_W + 1 + ADDR_W);
   localparam logic [CNT_W-1:0] L_WAKE  = CNT_W'(OP_W + PWD_W);
   localparam logic [KEY_W-1:0] KEY_V   = KEY_W'(TEST_KEY);

   logic [NBLK-1:0] blk_sel;
   logic            blk_lock;
   cmd_e            pick;
   logic            need_pwd;

   for (genvar b = 0; b < NBLK; b++) begin : g_blk
      assign blk_sel[b] = (addr == ADDR_W'(b)) && lock_bits[b];
   end
   assign blk_lock = |blk_sel;

   always_comb begin
      pick     = CMD_NONE;
      need_pwd = 1'b0;
      ignore   = 1'b0;
      if (cnt >= L_SHORT && cnt != CNT_W'(SAT)) begin
         unique case (op)
            2'b00: pick = (cnt == L_SHORT) ? CMD_RESET : CMD_NONE;
            2'b01: begin
               pick   = CMD_TEST;
               ignore = (master_key == KEY_V);
            end
            default: begin
               if (cnt == L_SHORT) begin
                  pick = CMD_PAGE;
               end else if (!pwd_mode) begin
                  if (cnt == L_WR)                 pick = CMD_WRITE;
                  else if (cnt == L_DA && !mark)   pick = CMD_DIRECT;
               end else begin
                  need_pwd = 1'b1;
                  if (cnt == L_WRP)                     pick = CMD_WRITE;
                  else if (cnt == L_DAP && !mark)       pick = CMD_DIRECT;
                  else if (cnt == L_WAKE && !op[0])     pick = CMD_WAKE;
               end
            end
         endcase
      end
   end

   assign pwd_fail = pwd_mode && op[1] && (cnt >= L_WAKE) && !pwd_ok;
   assign err      = int_err || (pick == CMD_NONE) || (need_pwd && !pwd_ok);
   assign typ      = err ? CMD_NONE : pick;
   assign locked   = !err && (pick == CMD_WRITE) && (blk_lock || otp);
endmodule

// File: rtl/dl_cmd_parser.sv
module dl_cmd_parser
   import dl_cmd_pkg::*;
#(
   parameter int PWD_W     = 32,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 3,
   parameter int NBLK      = 8,
   parameter int KEY_W     = 4,
   parameter int TEST_KEY  = 6,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_vld,
   input  logic              bit_val,
   input  logic              bit_err,
   input  logic              frame_end,
   input  logic              pwd_mode,
   input  logic              aor_mode,
   input  logic [KEY_W-1:0]  master_key,
   input  logic [PWD_W-1:0]  stored_pwd,
   input  logic [NBLK-1:0]   lock_bits,
   input  logic              otp,
   output logic              cmd_vld,
   output logic [2:0]        cmd_type,
   output logic              cmd_page,
   output logic              cmd_lock,
   output logic [DATA_W-1:0] cmd_data,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic              cmd_err,
   output logic              cmd_locked,
   output logic              cur_page,
   output logic              mod_en
);
   localparam int SAT   = OP_W + PWD_W + 1 + DATA_W + ADDR_W + 1;
   localparam int CNT_W = $clog2(SAT + 1);

   if (NBLK != (1 << ADDR_W)) begin : g_bad_blk
      $error("block count must match address width");
   end
   if (ADDR_W < 2 || DATA_W < 2 || PWD_W < 2) begin : g_bad_w
      $error("field widths too small");
   end
   if (TEST_KEY >= (1 << KEY_W)) begin : g_bad_key
      $error("test key does not fit key width");
   end

   logic [CNT_W-1:0]  idx;
   logic              pwd_ok;
   logic [OP_W-1:0]   op;
   logic              mark;
   logic [DATA_W-1:0] data;
   logic [ADDR_W-1:0] addr;
   logic              int_err;
   logic              awake;
   cmd_e              typ;
   logic              err, locked, ignore, pwd_fail;
   logic              page_cmd;

   dl_bit_counter #(.SAT(SAT), .CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .clr(frame_end), .idx(idx));

   dl_pwd_cmp #(.PWD_W(PWD_W), .OP_W(OP_W), .CNT_W(CNT_W), .MSB_FIRST(MSB_FIRST)) u_pwd (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val), .clr(frame_end),
      .idx(idx), .stored_pwd(stored_pwd), .ok(pwd_ok));

   dl_field_cap #(.OP_W(OP_W), .PWD_W(PWD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                  .CNT_W(CNT_W), .MSB_FIRST(MSB_FIRST)) u_cap (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val), .clr(frame_end),
      .pwd_mode(pwd_mode), .idx(idx), .op(op), .mark(mark), .data(data), .addr(addr));

   dl_decode #(.PWD_W(PWD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NBLK(NBLK), .KEY_W(KEY_W),
               .TEST_KEY(TEST_KEY), .CNT_W(CNT_W), .SAT(SAT)) u_dec (
      .cnt(idx), .op(op), .mark(mark), .pwd_ok(pwd_ok), .pwd_mode(pwd_mode),
      .int_err(int_err), .master_key(master_key), .addr(addr), .lock_bits(lock_bits),
      .otp(otp), .typ(typ), .err(err), .locked(locked), .ignore(ignore), .pwd_fail(pwd_fail));

   assign page_cmd = (typ == CMD_WRITE) || (typ == CMD_DIRECT) ||
                     (typ == CMD_PAGE)  || (typ == CMD_WAKE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_err <= 1'b0;
      end else if (frame_end) begin
         int_err <= 1'b0;
      end else if (bit_err) begin
         int_err <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_vld    <= 1'b0;
         cmd_type   <= CMD_NONE;
         cmd_page   <= 1'b0;
         cmd_lock   <= 1'b0;
         cmd_data   <= '0;
         cmd_addr   <= '0;
         cmd_err    <= 1'b0;
         cmd_locked <= 1'b0;
         cur_page   <= 1'b0;
         awake      <= 1'b0;
      end else begin
         cmd_vld <= 1'b0;
         if (frame_end && !ignore) begin
            cmd_vld    <= 1'b1;
            cmd_type   <= typ;
            cmd_page   <= op[0];
            cmd_lock   <= mark;
            cmd_data   <= data;
            cmd_addr   <= addr;
            cmd_err    <= err;
            cmd_locked <= locked;
            if (page_cmd) begin
               cur_page <= op[0];
            end else if (typ == CMD_RESET) begin
               cur_page <= 1'b0;
            end
            if (typ == CMD_WAKE) begin
               awake <= 1'b1;
            end else if (typ == CMD_RESET || pwd_fail) begin
               awake <= 1'b0;
            end
         end
      end
   end

   assign mod_en = !aor_mode || awake;

   // R11
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n) !(bit_vld && frame_end));
   // R11
   vld_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd_vld |-> $past(frame_end));
   // R7
   err_lock_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd_vld |-> !(cmd_err && cmd_locked));
   // R8
   err_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && cmd_err) |-> cmd_type == CMD_NONE);
   // R9
   page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur_page) |-> (cmd_vld && !cmd_err));
   // R10
   wake_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(awake) |-> (cmd_vld && cmd_type == CMD_WAKE));
   // R6
   test_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && cmd_type == CMD_TEST) |-> $past(master_key) != KEY_W'(TEST_KEY));
endmodule

// File: tb/dl_cmd_parser_tb.sv
module dl_cmd_parser_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_vld = 1'b0, bit_val = 1'b0, bit_err = 1'b0, frame_end = 1'b0;
   logic        pwd_mode = 1'b0, aor_mode = 1'b0, otp = 1'b0;
   logic [3:0]  master_key = 4'd9;
   logic [31:0] stored_pwd = 32'hC35A_96E1;
   logic [7:0]  lock_bits = 8'b1010_0110;
   logic        cmd_vld, cmd_page, cmd_lock, cmd_err, cmd_locked, cur_page, mod_en;
   logic [2:0]  cmd_type;
   logic [31:0] cmd_data;
   logic [2:0]  cmd_addr;

   int checks = 0, errors = 0;
   logic [127:0] fbuf;
   int flen = 0;
   logic exp_page = 1'b0, exp_awake = 1'b0;

   always #2.5 clk = ~clk;

   dl_cmd_parser u_dut (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val), .bit_err(bit_err),
      .frame_end(frame_end), .pwd_mode(pwd_mode), .aor_mode(aor_mode),
      .master_key(master_key), .stored_pwd(stored_pwd), .lock_bits(lock_bits), .otp(otp),
      .cmd_vld(cmd_vld), .cmd_type(cmd_type), .cmd_page(cmd_page), .cmd_lock(cmd_lock),
      .cmd_data(cmd_data), .cmd_addr(cmd_addr), .cmd_err(cmd_err), .cmd_locked(cmd_locked),
      .cur_page(cur_page), .mod_en(mod_en));

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic put(input logic [63:0] v, input int w);
      for (int i = w - 1; i >= 0; i--) begin
         fbuf[flen] = v[i];
         flen++;
      end
   endtask

   task automatic send(input bit glitch);
      for (int i = 0; i < flen; i++) begin
         @(negedge clk);
         bit_vld = 1'b1;
         bit_val = fbuf[i];
         bit_err = glitch && (i == 1);
      end
      @(negedge clk);
      bit_vld = 1'b0;
      bit_err = 1'b0;
      frame_end = 1'b1;
      @(negedge clk);
      frame_end = 1'b0;
      flen = 0;
   endtask

   // typ: expected type code; e/l: error and locked flags; pg: page bit of opcode
   task automatic expect_cmd(input string req, input int typ, input bit e, input bit l, input bit pg);
      chk(cmd_vld == 1'b1, req, "cmd_vld", cmd_vld, 1);
      chk(cmd_type == 3'(typ), req, "cmd_type", cmd_type, typ);
      chk(cmd_err == e, req, "cmd_err", cmd_err, e);
      chk(cmd_locked == l, req, "cmd_locked", cmd_locked, l);
      if (!e && (typ == 1 || typ == 2 || typ == 4 || typ == 5)) exp_page = pg;
      if (!e && typ == 3) exp_page = 1'b0;
      if (!e && typ == 5) exp_awake = 1'b1;
      if (!e && typ == 3) exp_awake = 1'b0;
      chk(cur_page == exp_page, "R9", "cur_page", cur_page, exp_page);
      chk(mod_en == (!aor_mode || exp_awake), "R10", "mod_en", mod_en, !aor_mode || exp_awake);
   endtask

   initial begin
      #1_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      // reset state: R11 R10 R9
      chk(cmd_vld == 1'b0, "R11", "reset cmd_vld", cmd_vld, 0);
      chk(cur_page == 1'b0, "R9", "reset cur_page", cur_page, 0);
      chk(mod_en == 1'b1, "R10", "reset mod_en", mod_en, 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R4 R7: plain write sweep over page, lock bit and address
      for (int p = 0; p < 2; p++)
         for (int lk = 0; lk < 2; lk++)
            for (int a = 0; a < 8; a++) begin
               d = 32'hA5C3_0F01 ^ (32'(a) * 32'h0101_0101) ^ (32'(p) << 7) ^ (32'(lk) << 19);
               put({1'b1, 1'(p)}, 2); put(64'(lk), 1); put(64'(d), 32); put(64'(a), 3);
               send(1'b0);
               expect_cmd("R2", 1, 1'b0, lock_bits[a], 1'(p));
               chk(cmd_data == d, "R4", "cmd_data", cmd_data, d);
               chk(cmd_addr == 3'(a), "R4", "cmd_addr", cmd_addr, a);
               chk(cmd_lock == 1'(lk), "R4", "cmd_lock", cmd_lock, lk);
               chk(cmd_page == 1'(p), "R1", "cmd_page", cmd_page, p);
               @(negedge clk);
               chk(cmd_vld == 1'b0, "R11", "pulse width", cmd_vld, 0);
            end

      // R2: direct access sweep, and a set third bit rejected
      for (int a = 0; a < 8; a++) begin
         put({1'b1, 1'(a & 1)}, 2); put(0, 1); put(64'(a), 3);
         send(1'b0);
         expect_cmd("R2", 2, 1'b0, 1'b0, 1'(a & 1));
         chk(cmd_addr == 3'(a), "R4", "direct addr", cmd_addr, a);
      end
      put(2'b10, 2); put(1, 1); put(3'd5, 3);
      send(1'b0);
      expect_cmd("R2", 0, 1'b1, 1'b0, 1'b0);

      // R8 R2: every length with opcode 10 followed by zeros
      for (int n = 1; n <= 75; n++) begin
         put(2'b10, (n < 2) ? n : 2);
         if (n > 2) put(0, n - 2);
         send(1'b0);
         if (n == 2)       expect_cmd("R2", 4, 1'b0, 1'b0, 1'b0);
         else if (n == 6)  expect_cmd("R2", 2, 1'b0, 1'b0, 1'b0);
         else if (n == 38) expect_cmd("R2", 1, 1'b0, 1'b0, 1'b0);
         else              expect_cmd("R8", 0, 1'b1, 1'b0, 1'b0);
      end

      // R1 R9: page read to page 1, then an error keeps it
      put(2'b11, 2); send(1'b0);
      expect_cmd("R1", 4, 1'b0, 1'b0, 1'b1);
      put(2'b11, 2); put(0, 3); send(1'b0);
      expect_cmd("R8", 0, 1'b1, 1'b0, 1'b1);
      // R8: legal write carrying an interval error
      put(2'b10, 2); put(0, 36); send(1'b1);
      expect_cmd("R8", 0, 1'b1, 1'b0, 1'b0);
      // R1 R9: reset command returns page 0; longer 00 frame is an error
      put(2'b00, 2); send(1'b0);
      expect_cmd("R1", 3, 1'b0, 1'b0, 1'b0);
      put(2'b11, 2); send(1'b0);
      expect_cmd("R9", 4, 1'b0, 1'b0, 1'b1);
      put(2'b00, 2); put(0, 4); send(1'b0);
      expect_cmd("R2", 0, 1'b1, 1'b0, 1'b0);

      // R6: test commands gated by key
      master_key = 4'd6;
      put(2'b01, 2); put(6'h2A, 6); send(1'b0);
      chk(cmd_vld == 1'b0, "R6", "ignored test vld", cmd_vld, 0);
      chk(cur_page == exp_page, "R6", "ignored test page", cur_page, exp_page);
      master_key = 4'd9;
      put(2'b01, 2); put(6'h2A, 6); send(1'b0);
      expect_cmd("R6", 6, 1'b0, 1'b0, 1'b1);

      // R7: global protection on an unlocked block (block 0)
      otp = 1'b1;
      put(2'b10, 2); put(0, 1); put(32'h1234_5678, 32); put(0, 3); send(1'b0);
      expect_cmd("R7", 1, 1'b0, 1'b1, 1'b0);
      otp = 1'b0;

      // R3: password mode length sweep, opcode 11 with the right password
      pwd_mode = 1'b1;
      for (int n = 2; n <= 75; n++) begin
         put(2'b11, 2);
         if (n > 2) begin
            if (n - 2 >= 32) begin
               put(64'(stored_pwd), 32);
               if (n > 34) put(0, n - 34);
            end else begin
               put(64'(stored_pwd >> (34 - n)), n - 2);
            end
         end
         send(1'b0);
         if (n == 2)       expect_cmd("R3", 4, 1'b0, 1'b0, 1'b1);
         else if (n == 38) expect_cmd("R3", 2, 1'b0, 1'b0, 1'b1);
         else if (n == 70) expect_cmd("R3", 1, 1'b0, 1'b0, 1'b1);
         else              expect_cmd("R3", 0, 1'b1, 1'b0, 1'b1);
      end

      // R4 R3: protected write field extraction
      put(2'b10, 2); put(64'(stored_pwd), 32); put(1, 1); put(32'hDEAD_0B1F, 32); put(3'd6, 3);
      send(1'b0);
      expect_cmd("R3", 1, 1'b0, 1'b0, 1'b0);
      chk(cmd_data == 32'hDEAD_0B1F, "R4", "pwd write data", cmd_data, 32'hDEAD_0B1F);
      chk(cmd_addr == 3'd6 && cmd_lock, "R4", "pwd write addr/lock", {cmd_lock, cmd_addr}, 4'hE);

      // R5: one wrong password bit at each position
      for (int k = 0; k < 32; k++) begin
         put(2'b10, 2); put(64'(stored_pwd ^ (32'h1 << (31 - k))), 32);
         put(0, 1); put(32'h0F0F_0F0F, 32); put(3'd3, 3);
         send(1'b0);
         expect_cmd("R5", 0, 1'b1, 1'b0, 1'b0);
      end

      // R10: answer-on-request wake flow
      aor_mode = 1'b1;
      @(negedge clk);
      chk(mod_en == 1'b0, "R10", "asleep mod_en", mod_en, 0);
      put(2'b10, 2); put(64'(stored_pwd), 32); send(1'b0);
      expect_cmd("R10", 5, 1'b0, 1'b0, 1'b0);
      put(2'b11, 2); put(64'(~stored_pwd), 32); put(0, 1); put(3'd2, 3); send(1'b0);
      exp_awake = 1'b0;
      expect_cmd("R10", 0, 1'b1, 1'b0, 1'b0);
      put(2'b10, 2); put(64'(stored_pwd), 32); send(1'b0);
      expect_cmd("R10", 5, 1'b0, 1'b0, 1'b0);
      put(2'b00, 2); send(1'b0);
      expect_cmd("R10", 3, 1'b0, 1'b0, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule